// File: doc/BRIEF.md
# Hamming SEC-DED Codec for Byte Data

This block guards one 8-bit data byte with a single-error-correcting, double-error-detecting Hamming code. The encoder side is purely combinational: a byte on `data_in` appears at once on `enc_code` as a 13-bit word. That word holds 12 Hamming bits, with four check bits at the power-of-two positions. It also holds one extra bit that makes the parity of the whole word even. A memory controller writes `enc_code` to storage and later presents the fetched word on `code_in`.

The decoder side recomputes the four check bits from the fetched data bits and XORs them with the stored check bits to form a 4-bit syndrome. Because of the layout, a non-zero syndrome equals the position number of a single flipped bit. The overall parity bit tells a single flip (odd) from a double flip (even). The decoder returns the corrected byte, the syndrome and two status flags. With `OUT_REG` = 1 (the default) these decoder results pass through one register stage. With `OUT_REG` = 0 they are combinational.

No state machine is needed. The only storage is the optional output register. It holds either the reset state (all zero) or the decode of the word seen at the previous rising clock edge.

Top module: `hsec_codec`

## Requirements
- R1: Bit index i of a 13-bit codeword holds Hamming position i+1. Check bits C1, C2, C4 and C8 sit at indices 0, 1, 3 and 7. Data bits D1 to D8 (`data_in[0]` to `data_in[7]`) sit at indices 2, 4, 5, 6, 8, 9, 10 and 11 in that order.
- R2: The encoder computes each check bit by XOR over data bits: C1 from D1 D2 D4 D5 D7, C2 from D1 D3 D4 D6 D7, C4 from D2 D3 D4 D8, and C8 from D5 D6 D7 D8.
- R3: `enc_code[12]` is set so that all 13 bits of `enc_code` have even parity.
- R4: `syndrome` bit 0, 1, 2 and 3 is the fetched C1, C2, C4 and C8 XORed with the value recomputed from the fetched data bits. A word as encoded gives syndrome 0, `single_err` = 0, `double_err` = 0 and the original byte.
- R5: Flipping exactly one data-bit position of a valid word gives syndrome equal to that position, `single_err` = 1, `double_err` = 0, and the original byte on `data_out`.
- R6: Flipping exactly one check-bit position (1, 2, 4, 8), or only the overall parity bit (index 12, syndrome 0), gives `single_err` = 1 and leaves `data_out` equal to the fetched data bits.
- R7: A non-zero syndrome with even overall parity (two flips) gives `double_err` = 1 and `single_err` = 0. `data_out` then equals the fetched data bits unchanged.
- R8: A syndrome of 13, 14 or 15 with odd overall parity names no real position. It gives `double_err` = 1 and `single_err` = 0, with the fetched data bits passed through unchanged.
- R9: `single_err` and `double_err` are never 1 together.
- R10: With `OUT_REG` = 1, `data_out`, `syndrome`, `single_err` and `double_err` show the decode of `code_in` as sampled at the previous rising edge of `clk`. A low `rst_n` clears them to zero at once.
- R11: Data 0x39 encodes to 13'h134F (12 Hamming bits 001101001111, parity bit 1). Fetched as 13'h136F (position 6 flipped), it decodes with syndrome 6, `single_err` = 1 and data 0x39.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 8 | Byte to encode |
| enc_code | output | 13 | Encoded word, combinational from `data_in` |
| code_in | input | 13 | Fetched word to decode |
| data_out | output | 8 | Corrected or passed-through byte |
| syndrome | output | 4 | Check-bit syndrome, C1 in bit 0 |
| single_err | output | 1 | One-bit error seen and handled |
| double_err | output | 1 | Uncorrectable error seen |

## Verification
A wrong position map or mask shows up on the next clock edge in one of two ways. It corrects the wrong data bit, or it corrects a data bit when only a check bit was hit. For that reason every byte value is swept against every single-bit flip. A fault in the parity or range logic shows up in the same cycle the faulty word is fetched, as a swapped or doubled status flag. A fault in the output register shows either as a result one cycle early or as a value that survives reset.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
    localparam int DW = 8;           // data bits
    localparam int KW = 4;           // Hamming check bits
    localparam int NW = DW + KW;     // Hamming positions 1..NW
    localparam int TW = NW + 1;      // plus overall parity

    // Hamming position of the i-th data bit: the i-th position that is not a power of two
    function automatic int data_pos(input int i);
        int n;
        n = 0;
        for (int p = 1; p < 64; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == i) return p;
                n++;
            end
        end
        return 0;
    endfunction

    // data bits covered by check bit k
    function automatic logic [DW-1:0] chk_mask(input int k);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) m[i] = ((data_pos(i) >> k) & 1) != 0;
        return m;
    endfunction
endpackage

// File: rtl/hsec_enc.sv
module hsec_enc
    import hsec_pkg::*;
(
    input  logic [DW-1:0] data,
    output logic [TW-1:0] code
);
    logic [NW-1:0] body;

    for (genvar k = 0; k < KW; k++) begin : g_chk
        localparam logic [DW-1:0] MASK = chk_mask(k);
        assign body[(1 << k) - 1] = ^(data & MASK);
    end

    for (genvar i = 0; i < DW; i++) begin : g_dat
        localparam int POS = data_pos(i);
        assign body[POS - 1] = data[i];
    end

    assign code = {^body, body};
endmodule

// File: rtl/hsec_syn.sv
module hsec_syn
    import hsec_pkg::*;
(
    input  logic [TW-1:0] code,
    output logic [DW-1:0] raw,
    output logic [KW-1:0] syn,
    output logic          par_bad
);
    for (genvar i = 0; i < DW; i++) begin : g_ext
        localparam int POS = data_pos(i);
        assign raw[i] = code[POS - 1];
    end

    for (genvar k = 0; k < KW; k++) begin : g_syn
        localparam logic [DW-1:0] MASK = chk_mask(k);
        assign syn[k] = code[(1 << k) - 1] ^ (^(raw & MASK));
    end

    assign par_bad = ^code;
endmodule

// File: rtl/hsec_fix.sv
module hsec_fix
    import hsec_pkg::*;
(
    input  logic [DW-1:0] raw,
    input  logic [KW-1:0] syn,
    input  logic          par_bad,
    output logic [DW-1:0] fixed,
    output logic          single,
    output logic          double
);
    localparam logic [KW-1:0] TOP_POS = KW'(NW);

    logic in_range;
    assign in_range = (syn <= TOP_POS);
    assign single   = par_bad && in_range;
    assign double   = (syn != '0) && (!par_bad || !in_range);

    for (genvar i = 0; i < DW; i++) begin : g_fix
        localparam logic [KW-1:0] POS = KW'(data_pos(i));
        assign fixed[i] = raw[i] ^ (single && (syn == POS));
    end
endmodule

// File: rtl/hsec_codec.sv
module hsec_codec
    import hsec_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    data_in,
    output logic [12:0]   enc_code,
    input  logic [12:0]   code_in,
    output logic [7:0]    data_out,
    output logic [3:0]    syndrome,
    output logic          single_err,
    output logic          double_err
);
    logic [DW-1:0] raw, fixed;
    logic [KW-1:0] syn;
    logic          par_bad, single, double;

    hsec_enc u_enc (.data(data_in), .code(enc_code));

    hsec_syn u_syn (.code(code_in), .raw(raw), .syn(syn), .par_bad(par_bad));

    hsec_fix u_fix (
        .raw(raw), .syn(syn), .par_bad(par_bad),
        .fixed(fixed), .single(single), .double(double)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_out   <= '0;
                syndrome   <= '0;
                single_err <= 1'b0;
                double_err <= 1'b0;
            end else begin
                data_out   <= fixed;
                syndrome   <= syn;
                single_err <= single;
                double_err <= double;
            end
        end
    end else begin : g_comb
        assign data_out   = fixed;
        assign syndrome   = syn;
        assign single_err = single;
        assign double_err = double;
    end
endmodule

// File: rtl/hsec_codec_chk.sv
module hsec_codec_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  data_in,
    input logic [12:0] enc_code,
    input logic [12:0] code_in,
    input logic [7:0]  data_out,
    input logic [3:0]  syndrome,
    input logic        single_err,
    input logic        double_err
);
    logic [12:0] code_q;
    logic        primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            primed <= 1'b0;
        end else begin
            code_q <= code_in;
            primed <= 1'b1;
        end
    end

    logic [12:0] cv;
    logic [7:0]  raw_v;
    assign cv    = OUT_REG ? code_q : code_in;
    assign raw_v = {cv[11], cv[10], cv[9], cv[8], cv[6], cv[5], cv[4], cv[2]};

    // R3: encoder output always has even parity
    a_r3_even_word: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_code) == 1'b0);

    // R1: encoder data bits sit at their fixed positions
    a_r1_data_place: assert property (@(posedge clk) disable iff (!rst_n)
        {enc_code[11], enc_code[10], enc_code[9], enc_code[8],
         enc_code[6], enc_code[5], enc_code[4], enc_code[2]} == data_in);

    // R9: flags exclusive
    a_r9_flag_mutex: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_err && double_err));

    // R7: uncorrectable errors pass data through
    a_r7_double_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && double_err) |-> (data_out == raw_v));

    // R4: clean words report zero syndrome and raw data
    a_r4_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !single_err && !double_err) |-> (syndrome == 4'd0 && data_out == raw_v));

    // R6: zero syndrome with odd parity is a parity-bit-only error
    a_r6_parity_only: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && syndrome == 4'd0 && (^cv)) |-> (single_err && data_out == raw_v));
endmodule

bind hsec_codec hsec_codec_chk #(.OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_hsec_codec.sv
`timescale 1ns/1ps
module sim_hsec_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  data_in = '0;
    logic [12:0] enc_code;
    logic [12:0] code_in = '0;
    logic [7:0]  data_out;
    logic [3:0]  syndrome;
    logic        single_err, double_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hsec_codec u0 (.*);

    // reference encoder written from the check equations (R1, R2, R3)
    function automatic logic [12:0] ref_enc(input logic [7:0] d);
        logic c1, c2, c4, c8;
        logic [11:0] b;
        c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
        c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
        c4 = d[1] ^ d[2] ^ d[3] ^ d[7];
        c8 = d[4] ^ d[5] ^ d[6] ^ d[7];
        b = {d[7], d[6], d[5], d[4], c8, d[3], d[2], d[1], c4, d[0], c2, c1};
        return {^b, b};
    endfunction

    function automatic logic [7:0] raw_of(input logic [12:0] c);
        return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
    endfunction

    function automatic logic [3:0] syn_of(input logic [12:0] flip);
        logic [3:0] s;
        s = '0;
        for (int b = 0; b < 12; b++) if (flip[b]) s ^= 4'(b + 1);
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // apply a fetched word at a falling edge, sample after the next rising edge
    task automatic fetch(input logic [12:0] w);
        @(negedge clk);
        code_in = w;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  d;
        logic [12:0] flip;
        logic        s;
        logic        dd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{8'h39, 13'h0000, 1'b0, 1'b0},   // R4 clean
        '{8'h39, 13'h0020, 1'b1, 1'b0},   // R11/R5 position 6
        '{8'h00, 13'h0000, 1'b0, 1'b0},   // R4
        '{8'hFF, 13'h0800, 1'b1, 1'b0},   // R5 position 12
        '{8'hA5, 13'h0001, 1'b1, 1'b0},   // R6 position 1
        '{8'h5A, 13'h0080, 1'b1, 1'b0},   // R6 position 8
        '{8'hC3, 13'h1000, 1'b1, 1'b0},   // R6 parity bit only
        '{8'h39, 13'h0014, 1'b0, 1'b1},   // R7 positions 3,5
        '{8'h7E, 13'h0089, 1'b0, 1'b1},   // R8 syndrome 13
        '{8'h12, 13'h1100, 1'b0, 1'b1},   // R7 position 9 + parity
        '{8'h81, 13'h0004, 1'b1, 1'b0},   // R5 position 3
        '{8'hFF, 13'h0000, 1'b0, 1'b0}    // R4
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            wrap_up();
        end
    end

    initial begin
        // R10: reset state with a faulty word on the input
        code_in = 13'h0014;
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {data_out, syndrome, single_err, double_err}, '0);
        rst_n = 1'b1;

        // R11: stated vector
        @(negedge clk);
        data_in = 8'h39;
        #1;
        chk("R11 encode 0x39", enc_code, 13'h134F);
        fetch(13'h136F);
        chk("R11 syndrome", syndrome, 4'd6);
        chk("R11 data/flags", {data_out, single_err, double_err}, {8'h39, 1'b1, 1'b0});

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [12:0] cw;
            logic [7:0]  ed;
            @(negedge clk);
            data_in = VT[v].d;
            #1;
            cw = enc_code;
            chk("R1 R2 R3 table encode", cw, ref_enc(VT[v].d));
            ed = VT[v].dd ? raw_of(cw ^ VT[v].flip) : VT[v].d;
            fetch(cw ^ VT[v].flip);
            chk("R4 R5 R6 R7 R8 R9 table flags", {single_err, double_err}, {VT[v].s, VT[v].dd});
            chk("R5 R7 R8 table data", data_out, ed);
            chk("R4 table syndrome", syndrome, syn_of(VT[v].flip));
        end

        // R10: output holds until the capturing edge
        @(negedge clk);
        code_in = ref_enc(8'h5A) ^ 13'h0100;   // position 9 flipped
        #1;
        chk("R10 no early update", {data_out, single_err}, {8'hFF, 1'b0});
        @(negedge clk);
        chk("R10 after edge", {data_out, single_err, syndrome}, {8'h5A, 1'b1, 4'd9});

        // sweep: every byte, clean and each single flip (R1 R2 R5 R6)
        for (int d = 0; d < 256; d++) begin
            for (int b = -1; b < 13; b++) begin
                logic [12:0] fl;
                fl = (b < 0) ? 13'h0 : 13'(1 << b);
                fetch(ref_enc(8'(d)) ^ fl);
                chk("R5 R6 sweep", {data_out, single_err, double_err},
                    {8'(d), (b >= 0), 1'b0});
            end
        end

        // R10: reset mid-run clears outputs at once
        fetch(13'h136F);
        #3 rst_n = 1'b0;
        #1;
        chk("R10 async clear", {data_out, syndrome, single_err, double_err}, '0);
        done = 1'b1;
        wrap_up();
    end
endmodule